// File: doc/BRIEF.md
# Flash Crypto Region Decoder

This block sits beside an inline flash cipher and decides, for each flash access address, whether the cipher applies and which of three key slots it uses. Software sets up three crypto regions. Each region has a 2-bit base select that places it on a 256 kB boundary. Each region also has a bitmap with one enable bit per 8 kB subregion. The enabled subregions need not be contiguous, and two regions may share a base so that different keys guard different parts of one 256 kB window.

The block also judges erase and program requests, given as a start address and a byte length. A request passes only if, for every region whose enabled subregions it overlaps, it covers exactly that region's enabled span. The enabled span runs from the start of the lowest enabled subregion to the end of the highest enabled subregion. A request of zero length, or one longer than a region (256 kB), fails.

The address decode and the range check are independent, and both are registered.

Top module: `flash_crypt_region_decoder`

## Requirements
- R1: Three regions exist. On a hit, key_idx reports the number of the region that matched: 0, 1 or 2.
- R2: Config word address 2*r holds the base register of region r. Its bits [19:18] select the base, so region r covers flash addresses sel*0x40000 up to sel*0x40000+0x3FFFF. A select of 0 maps the region to 0x00000–0x3FFFF.
- R3: Config word address 2*r+1 holds the enable bitmap of region r. Bit i enables subregion i, which is addr[17:13] of the access address. Enabled subregions may be non-contiguous.
- R4: Regions 0 and 1 have 32 subregions each. Region 2 has 16 subregions. Enable bits 16–31 of region 2 have no effect on decode or on range checks.
- R5: When more than one region hits the same address, the lowest-numbered region supplies key_idx.
- R6: An address that hits no region gives crypto_hit 0 and key_idx 0.
- R7: Reset clears every base and enable register. crypto_hit and key_idx follow acc_addr with exactly one cycle of latency.
- R8: A range request with length 0 fails. A range request with length above 0x40000 fails. A length of exactly 0x40000 is allowed.
- R9: A range request fails if, for any region whose enabled subregions it overlaps, the request differs from that region's enabled span. A request that overlaps no enabled subregion passes.
- R10: chk_done is a single-cycle pulse, one cycle after each chk_valid cycle, and chk_pass is meaningful with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 3 | Config word address |
| cfg_wdata | input | 32 | Config write data |
| acc_addr | input | 20 | Flash access address to decode |
| crypto_hit | output | 1 | Cipher applies to the previous cycle's address |
| key_idx | output | 2 | Key slot for the hit |
| chk_valid | input | 1 | Range request strobe |
| chk_start | input | 20 | Range request start address |
| chk_len | input | 21 | Range request length in bytes |
| chk_done | output | 1 | Range verdict pulse |
| chk_pass | output | 1 | Range verdict, 1 when the request is acceptable |

## Verification
The address decode and the range checker share the configuration registers but have separate output registers, so an access and a range request can fall in the same cycle. The bench provokes this by driving an access address and a range request on the same negative clock edge in most steps, often touching the same region. Each scoreboard item carries both the expected decode result and the expected verdict, and the monitor judges them together one edge later. A fault in either path, or leakage between the two, shows up as a mismatch.

// File: rtl/fcr_pkg.sv
// Package: shared geometry of the flash crypto region decoder.
// Assumes a flash of FLASH_BYTES, windows of 2**REGION_SHIFT bytes and
// subregions of 2**SUB_SHIFT bytes.
package fcr_pkg;
    localparam int ADDR_W       = 20;
    localparam int SUB_SHIFT    = 13;
    localparam int REGION_SHIFT = 18;
    localparam int NUM_REGIONS  = 3;
    localparam int FLASH_BYTES  = 640 * 1024;
    localparam int DATA_W       = 32;

    localparam int SUBS         = 1 << (REGION_SHIFT - SUB_SHIFT);
    localparam int SUBIDX_W     = REGION_SHIFT - SUB_SHIFT;
    localparam int BASE_W       = ADDR_W - REGION_SHIFT;
    localparam int KEY_W        = $clog2(NUM_REGIONS);
    localparam int REG_AW       = $clog2(NUM_REGIONS) + 1;
    localparam int LEN_W        = ADDR_W + 1;
    localparam int END_W        = ADDR_W + 2;
    localparam int REGION_BYTES = 1 << REGION_SHIFT;

    // Number of subregions that exist in region idx, given the flash size.
    function automatic int region_subs(input int idx);
        int remain;
        remain = FLASH_BYTES - idx * REGION_BYTES;
        if (remain > REGION_BYTES) remain = REGION_BYTES;
        if (remain < 0) remain = 0;
        return remain >> SUB_SHIFT;
    endfunction
endpackage

// File: rtl/fcr_cfg_regs.sv
// Module: configuration registers for all regions.
// Word address {region, kind}: kind 0 = base (select in bits [19:18]),
// kind 1 = subregion enable bitmap. Enable bits beyond a region's size
// are dropped on write. Writes to absent regions have no effect.
module fcr_cfg_regs
    import fcr_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic [REG_AW-1:0]                     cfg_addr,
    input  logic [DATA_W-1:0]                     cfg_wdata,
    output logic [NUM_REGIONS-1:0][BASE_W-1:0]    base_sel,
    output logic [NUM_REGIONS-1:0][SUBS-1:0]      enable
);
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
        localparam int NS = region_subs(r);
        localparam logic [SUBS-1:0] MASK =
            (NS >= SUBS) ? {SUBS{1'b1}} : SUBS'((64'(1) << NS) - 64'(1));
        logic sel_this;
        assign sel_this = cfg_we && (cfg_addr[REG_AW-1:1] == (REG_AW-1)'(r));

        // Base select register of this region.
        always_ff @(posedge clk) begin
            if (!rst_n)                       base_sel[r] <= '0;
            else if (sel_this && !cfg_addr[0]) base_sel[r] <= cfg_wdata[REGION_SHIFT +: BASE_W];
        end

        // Enable bitmap of this region, masked to its real size.
        always_ff @(posedge clk) begin
            if (!rst_n)                      enable[r] <= '0;
            else if (sel_this && cfg_addr[0]) enable[r] <= cfg_wdata[SUBS-1:0] & MASK;
        end

        AST_EN_IN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
            (enable[r] & ~MASK) == '0); // R4
    end
endmodule

// File: rtl/fcr_region_unit.sv
// Module: per-region match logic.
// Gives the address hit, whether a range request overlaps an enabled
// subregion, and whether it equals the enabled span exactly.
// Assumes the enable bitmap is already masked to the region size.
module fcr_region_unit
    import fcr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BASE_W-1:0]   base_sel,
    input  logic [SUBS-1:0]     enable,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [ADDR_W-1:0]   chk_start,
    input  logic [END_W-1:0]    chk_end,
    output logic                acc_hit,
    output logic                touched,
    output logic                exact
);
    localparam logic [END_W-1:0] SUB_BYTES = END_W'(1) << SUB_SHIFT;

    logic [END_W-1:0]    base_off;
    logic [SUBIDX_W-1:0] lo_idx, hi_idx;
    logic [END_W-1:0]    span_lo, span_hi;
    logic                any_en;

    assign base_off = END_W'(base_sel) << REGION_SHIFT;

    // Address hit: right window and enabled subregion.
    always_comb begin
        acc_hit = (acc_addr[ADDR_W-1:REGION_SHIFT] == base_sel) &&
                  enable[acc_addr[REGION_SHIFT-1:SUB_SHIFT]];
    end

    // Overlap of the request with any enabled subregion.
    always_comb begin
        touched = 1'b0;
        for (int i = 0; i < SUBS; i++) begin
            logic [END_W-1:0] s_lo;
            s_lo = base_off + (END_W'(i) << SUB_SHIFT);
            if (enable[i] && (END_W'(chk_start) < s_lo + SUB_BYTES) && (chk_end > s_lo))
                touched = 1'b1;
        end
    end

    // Lowest and highest enabled subregion indices.
    always_comb begin
        lo_idx = '0;
        hi_idx = '0;
        for (int i = SUBS - 1; i >= 0; i--) if (enable[i]) lo_idx = SUBIDX_W'(i);
        for (int i = 0; i < SUBS; i++)      if (enable[i]) hi_idx = SUBIDX_W'(i);
    end

    // Exact coverage of the enabled span.
    always_comb begin
        any_en  = |enable;
        span_lo = base_off + (END_W'(lo_idx) << SUB_SHIFT);
        span_hi = base_off + ((END_W'(hi_idx) + END_W'(1)) << SUB_SHIFT);
        exact   = any_en && (END_W'(chk_start) == span_lo) && (chk_end == span_hi);
    end

    AST_EXACT_TOUCHES: assert property (@(posedge clk) disable iff (!rst_n)
        exact |-> touched); // R9
endmodule

// File: rtl/fcr_range_judge.sv
// Module: combines per-region overlap and exactness into a verdict.
// Assumes chk_len is the byte length of the request.
module fcr_range_judge
    import fcr_pkg::*;
(
    input  logic [LEN_W-1:0]        chk_len,
    input  logic [NUM_REGIONS-1:0]  touched,
    input  logic [NUM_REGIONS-1:0]  exact,
    output logic                    pass
);
    // Length bounds first, then each touched region must be exact.
    always_comb begin
        pass = (chk_len != '0) && (chk_len <= LEN_W'(REGION_BYTES));
        for (int r = 0; r < NUM_REGIONS; r++)
            if (touched[r] && !exact[r]) pass = 1'b0;
    end
endmodule

// File: rtl/flash_crypt_region_decoder.sv
// Module: top of the flash crypto region decoder.
// Registers the address decode (lowest region wins) and the range verdict,
// each one cycle after its input. Synchronous active-low reset.
module flash_crypt_region_decoder
    import fcr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [REG_AW-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic                crypto_hit,
    output logic [KEY_W-1:0]    key_idx,
    input  logic                chk_valid,
    input  logic [ADDR_W-1:0]   chk_start,
    input  logic [LEN_W-1:0]    chk_len,
    output logic                chk_done,
    output logic                chk_pass
);
    logic [NUM_REGIONS-1:0][BASE_W-1:0] base_sel;
    logic [NUM_REGIONS-1:0][SUBS-1:0]   enable;
    logic [NUM_REGIONS-1:0]             hit_v, touched_v, exact_v;
    logic [END_W-1:0]                   chk_end;
    logic                               hit_c, pass_c;
    logic [KEY_W-1:0]                   key_c;

    fcr_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .base_sel(base_sel), .enable(enable)
    );

    assign chk_end = END_W'(chk_start) + END_W'(chk_len);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_unit
        fcr_region_unit u_unit (
            .clk(clk), .rst_n(rst_n),
            .base_sel(base_sel[r]), .enable(enable[r]),
            .acc_addr(acc_addr), .chk_start(chk_start), .chk_end(chk_end),
            .acc_hit(hit_v[r]), .touched(touched_v[r]), .exact(exact_v[r])
        );
    end

    fcr_range_judge u_judge (
        .chk_len(chk_len), .touched(touched_v), .exact(exact_v), .pass(pass_c)
    );

    // Priority select: the lowest-numbered hitting region supplies the key.
    always_comb begin
        hit_c = 1'b0;
        key_c = '0;
        for (int r = NUM_REGIONS - 1; r >= 0; r--)
            if (hit_v[r]) begin
                hit_c = 1'b1;
                key_c = KEY_W'(r);
            end
    end

    // Decode output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crypto_hit <= 1'b0;
            key_idx    <= '0;
        end else begin
            crypto_hit <= hit_c;
            key_idx    <= key_c;
        end
    end

    // Range verdict register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_done <= 1'b0;
            chk_pass <= 1'b0;
        end else begin
            chk_done <= chk_valid;
            chk_pass <= chk_valid && pass_c;
        end
    end

    AST_CHK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_done); // R10
    AST_DONE_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_done); // R10
    AST_ZERO_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_len == '0) |=> !chk_pass); // R8
    AST_OVERSIZE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_len > LEN_W'(REGION_BYTES)) |=> !chk_pass); // R8
    AST_KEY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        crypto_hit |-> (key_idx < KEY_W'(NUM_REGIONS))); // R1
    AST_MISS_KEY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !crypto_hit |-> (key_idx == '0)); // R6
endmodule

// File: tb/tb_flash_crypt_region_decoder.sv
`timescale 1ns/1ps
module tb_flash_crypt_region_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [19:0] acc_addr = '0;
    logic        crypto_hit;
    logic [1:0]  key_idx;
    logic        chk_valid = 1'b0;
    logic [19:0] chk_start = '0;
    logic [20:0] chk_len = '0;
    logic        chk_done, chk_pass;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic       exp_hit;
        logic [1:0] exp_key;
        logic       has_chk;
        logic       exp_pass;
        string      tag;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk; // 125 MHz

    flash_crypt_region_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .crypto_hit(crypto_hit),
        .key_idx(key_idx), .chk_valid(chk_valid), .chk_start(chk_start),
        .chk_len(chk_len), .chk_done(chk_done), .chk_pass(chk_pass)
    );

    task automatic judge(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        chk_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: one access plus optional range request, expectation queued.
    task automatic step(input logic [19:0] a, input logic eh, input logic [1:0] ek,
                        input logic hc, input logic [19:0] s, input logic [20:0] l,
                        input logic ep, input string tag);
        item_t it;
        @(negedge clk);
        acc_addr = a; chk_valid = hc; chk_start = s; chk_len = l;
        it.exp_hit = eh; it.exp_key = ek; it.has_chk = hc; it.exp_pass = ep; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        chk_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop one item per cycle after the edge that registered it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                judge(crypto_hit === it.exp_hit, it.tag, "crypto_hit", crypto_hit, it.exp_hit);
                judge(key_idx === it.exp_key, it.tag, "key_idx", key_idx, it.exp_key);
                judge(chk_done === it.has_chk, it.tag, "chk_done", chk_done, it.has_chk);
                if (it.has_chk)
                    judge(chk_pass === it.exp_pass, it.tag, "chk_pass", chk_pass, it.exp_pass);
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        judge(crypto_hit === 1'b0, "R7", "reset crypto_hit", crypto_hit, 0);
        judge(key_idx === 2'd0, "R7", "reset key_idx", key_idx, 0);
        judge(chk_done === 1'b0, "R7", "reset chk_done", chk_done, 0);
        step(20'h00000, 0, 0, 1, 20'h00000, 21'h02000, 1, "R7"); // all cleared, passes R9
        idle();

        // Region 0: base 0, subs 2,3,7. Region 1: base sel 1, sub 0.
        // Region 2: base 0, subs 3,4 plus bit 20 which must be dropped.
        wr(3'd0, 32'h0000_0000);
        wr(3'd1, 32'h0000_008C);
        wr(3'd2, 32'h0004_0000);
        wr(3'd3, 32'h0000_0001);
        wr(3'd4, 32'h0000_0000);
        wr(3'd5, 32'h0010_0018);

        step(20'h04000, 1, 0, 0, 0, 0, 0, "R3");
        step(20'h02000, 0, 0, 0, 0, 0, 0, "R6");
        step(20'h0E000, 1, 0, 0, 0, 0, 0, "R3");
        step(20'h0A000, 0, 0, 0, 0, 0, 0, "R6");
        step(20'h40000, 1, 1, 0, 0, 0, 0, "R2");
        step(20'h42000, 0, 0, 0, 0, 0, 0, "R2");
        step(20'h06000, 1, 0, 0, 0, 0, 0, "R5");
        step(20'h08000, 1, 2, 0, 0, 0, 0, "R1");
        step(20'h28000, 0, 0, 0, 0, 0, 0, "R4");
        // Access and range request in the same cycle.
        step(20'h40000, 1, 1, 1, 20'h40000, 21'h00000, 0, "R8");
        step(20'h0E000, 1, 0, 1, 20'h80000, 21'h40001, 0, "R8");
        step(20'h08000, 1, 2, 1, 20'h40000, 21'h02000, 1, "R9");
        step(20'h40000, 1, 1, 1, 20'h40000, 21'h01000, 0, "R9");
        step(20'h06000, 1, 0, 1, 20'h04000, 21'h0C000, 0, "R9");
        step(20'h02000, 0, 0, 1, 20'h06000, 21'h04000, 0, "R9");
        step(20'h04000, 1, 0, 1, 20'h80000, 21'h40000, 1, "R8");
        step(20'h04000, 1, 0, 0, 0, 0, 0, "R10");
        idle();

        // Region 2 keeps only the out-of-size bit: no effect anywhere.
        wr(3'd5, 32'h0010_0000);
        step(20'h08000, 0, 0, 1, 20'h28000, 21'h02000, 1, "R4");
        step(20'h06000, 1, 0, 1, 20'h04000, 21'h0C000, 1, "R9");
        step(20'h0E000, 1, 0, 1, 20'h04000, 21'h0A000, 0, "R9");
        step(20'h40000, 1, 1, 1, 20'h02000, 21'h0E000, 0, "R9");
        idle();

        // Move region 0 onto region 1's window.
        wr(3'd0, 32'h0004_0000);
        step(20'h44000, 1, 0, 0, 0, 0, 0, "R2");
        step(20'h04000, 0, 0, 0, 0, 0, 0, "R2");
        step(20'h40000, 1, 1, 0, 0, 0, 0, "R5");
        idle();

        // Reset clears configuration.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(20'h44000, 0, 0, 0, 0, 0, 0, "R7");
        step(20'h40000, 0, 0, 0, 0, 0, 0, "R7");
        idle();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule